// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits between a simple request port and a single-rank SDRAM with two internal banks, an 11-bit row address, an 8-bit column address and a 32-bit data path. After reset it runs the power-up sequence. First it waits a programmable settling time. Then it closes every bank, issues two refresh commands and programs the mode register for single-word bursts with the configured CAS latency. Only after that does it accept user traffic.

Each user request names a bank, a row and a column. A write request also carries a data word and a per-byte mask. The sequencer keeps track of the open row in each bank. A request that hits the open row is served with a single READ or WRITE. A request that misses first closes only the addressed bank and then opens the new row. All command spacing is counted in clock cycles, and every spacing value is a parameter. Refresh requests come from a free-running interval counter and take priority over user work. Any open rows are closed before the refresh command is issued.

Read data comes back on a separate result port, in request order and at a fixed latency. The data bus is split into a driven output, an output enable and a sampled input. A pad wrapper joins them.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: Every command is driven as a fixed pattern on {cs_n, ras_n, cas_n, we_n}. NOP is 0111, ACTIVE is 0011, READ is 0101, WRITE is 0100, PRECHARGE is 0010, AUTO REFRESH is 0001 and LOAD MODE is 0000. No other pattern appears after reset.
- R2: After reset, only NOPs are driven for at least T_INIT cycles. The sequence is then PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH and LOAD MODE, with no other command in between. req_ready stays low until this sequence has completed.
- R3: The LOAD MODE opcode has the CAS latency on A[6:4] and zero on A[3:0], which selects a one-word sequential burst. Every other address bit is zero, and the bank lines are zero.
- R4: ACTIVE puts the row on A[10:0] and the bank on the bank lines. READ and WRITE put the column on A[7:0] and keep A10 low, so no automatic precharge is requested.
- R5: A request to the row already open in its bank is served by READ or WRITE without a new ACTIVE.
- R6: A request to a different row in an open bank is preceded by a PRECHARGE with A10 low that names only that bank. The other bank keeps its open row.
- R7: Minimum spacing in cycles is enforced. ACTIVE to READ/WRITE in the same bank is at least T_RCD. PRECHARGE to ACTIVE is at least T_RP. ACTIVE to PRECHARGE is at least T_RAS. ACTIVE to ACTIVE in the same bank, and refresh to ACTIVE or refresh, are at least T_RC. LOAD MODE to the next command is at least T_MRD. WRITE to PRECHARGE is at least T_WR.
- R8: Write data, the bus output enable and the byte mask are driven in the same cycle as WRITE. A mask bit of 1 blocks the matching byte lane; bit i covers data bits 8i+7..8i.
- R9: Read data sampled CAS_LAT cycles after a READ is presented on rd_data, with rd_valid high, one cycle later. Results come back in request order.
- R10: An AUTO REFRESH is issued at least once in every T_REFI cycles plus the time needed to close rows. While a refresh is due, no user request is accepted. Before the refresh, all open banks are closed with PRECHARGE and A10 high.
- R11: CKE is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A user request is presented |
| req_ready | output | 1 | The request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_row | input | 11 | Target row |
| req_col | input | 8 | Target column |
| req_wdata | input | 32 | Write data |
| req_wmask | input | 4 | Per-byte write mask, 1 blocks the byte |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 32 | Read result |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank address |
| sd_addr | output | 11 | Row, column or opcode |
| sd_dqm | output | 4 | Byte mask lines |
| sd_dq_out | output | 32 | Data to the SDRAM |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 32 | Data from the SDRAM |

## Verification
A wrong open-row record in a bank tracker shows up at the ports in one of two ways. Either a READ or WRITE goes to a bank the memory model holds closed, or a hit pays an extra ACTIVE, and either is visible on the very next command of that bank. A stale age counter produces a spacing violation on the first command that follows too early, which the model measures in cycles against each bank's history. A broken capture pipeline or mask path shows up as wrong data when the location is read back, CAS_LAT+1 cycles after that READ. A stuck refresh timer is caught once the refresh gap exceeds its bound.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;
   // Bit order {cs_n, ras_n, cas_n, we_n}; the patterns are fixed by the memory.
   typedef enum logic [3:0] {
      CMD_NOP  = 4'b0111,
      CMD_ACT  = 4'b0011,
      CMD_RD   = 4'b0101,
      CMD_WR   = 4'b0100,
      CMD_PRE  = 4'b0010,
      CMD_REF  = 4'b0001,
      CMD_LMR  = 4'b0000
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_POWERUP,
      ST_INIT_REF1,
      ST_INIT_REF2,
      ST_INIT_LMR,
      ST_RUN
   } seq_state_e;
endpackage

// File: rtl/sdr_bank_track.sv
`timescale 1ns/1ps
module sdr_bank_track #(
   parameter int ROW_W = 11,
   parameter int AGE_W = 6,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 6,
   parameter int T_RC  = 10,
   parameter int T_WR  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic             do_rd,
   input  logic             do_wr,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             rdwr_ok,
   output logic             pre_ok,
   output logic             act_ok
);
   localparam logic [AGE_W-1:0] AGE_SAT = '1;
   localparam logic [AGE_W-1:0] ONE     = AGE_W'(1);

   // Ages count cycles since the command was on the pins (1 in that cycle).
   logic [AGE_W-1:0] act_age, pre_age, wr_age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         open_row <= '0;
         act_age  <= AGE_SAT;
         pre_age  <= AGE_SAT;
         wr_age   <= AGE_SAT;
      end else begin
         if (act_age != AGE_SAT) act_age <= act_age + ONE;
         if (pre_age != AGE_SAT) pre_age <= pre_age + ONE;
         if (wr_age  != AGE_SAT) wr_age  <= wr_age  + ONE;
         if (do_act) begin
            is_open  <= 1'b1;
            open_row <= row_in;
            act_age  <= ONE;
         end
         if (do_pre) begin
            is_open <= 1'b0;
            pre_age <= ONE;
         end
         if (do_wr) wr_age <= ONE;
      end
   end

   assign rdwr_ok = is_open && (act_age >= AGE_W'(T_RCD));
   assign pre_ok  = (act_age >= AGE_W'(T_RAS)) && (wr_age >= AGE_W'(T_WR));
   assign act_ok  = !is_open && (pre_age >= AGE_W'(T_RP)) && (act_age >= AGE_W'(T_RC));

   assert_act_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |-> (!is_open && pre_age >= AGE_W'(T_RP) && act_age >= AGE_W'(T_RC)));
   assert_rdwr_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd || do_wr) |-> (is_open && act_age >= AGE_W'(T_RCD)));
   assert_pre_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pre && is_open) |-> (act_age >= AGE_W'(T_RAS) && wr_age >= AGE_W'(T_WR)));
endmodule

// File: rtl/sdr_ref_timer.sv
`timescale 1ns/1ps
module sdr_ref_timer #(
   parameter int T_REFI = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ref_done,
   output logic ref_due
);
   localparam int CNT_W = $clog2(T_REFI + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(T_REFI - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         ref_due <= 1'b0;
      end else begin
         if (ref_done) ref_due <= 1'b0;
         if (enable) begin
            if (cnt == LAST) begin
               cnt     <= '0;
               ref_due <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assert_due_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_done && cnt != LAST) |=> !ref_due);
endmodule

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sdram_seq_ctrl
   import sdr_seq_pkg::*;
#(
   parameter int ROW_W   = 11,
   parameter int COL_W   = 8,
   parameter int DATA_W  = 32,
   parameter int NBANK   = 2,
   parameter int CAS_LAT = 3,
   parameter int T_INIT  = 12500,
   parameter int T_RCD   = 3,
   parameter int T_RP    = 3,
   parameter int T_RAS   = 6,
   parameter int T_RC    = 10,
   parameter int T_MRD   = 2,
   parameter int T_WR    = 2,
   parameter int T_REFI  = 1950
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [$clog2(NBANK)-1:0] req_bank,
   input  logic [ROW_W-1:0]         req_row,
   input  logic [COL_W-1:0]         req_col,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [DATA_W/8-1:0]      req_wmask,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     sd_cke,
   output logic                     sd_cs_n,
   output logic                     sd_ras_n,
   output logic                     sd_cas_n,
   output logic                     sd_we_n,
   output logic [$clog2(NBANK)-1:0] sd_ba,
   output logic [ROW_W-1:0]         sd_addr,
   output logic [DATA_W/8-1:0]      sd_dqm,
   output logic [DATA_W-1:0]        sd_dq_out,
   output logic                     sd_dq_oe,
   input  logic [DATA_W-1:0]        sd_dq_in
);
   localparam int BA_W   = $clog2(NBANK);
   localparam int MASK_W = DATA_W / 8;
   localparam int GAP_W  = $clog2(T_INIT + T_RC + T_MRD + T_RP + 2) + 1;
   localparam int AGE_W  = $clog2(T_RC + T_RAS + T_RCD + T_RP + T_WR + 2);
   localparam int AP_BIT = 10;
   localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

   if (ROW_W < 11) begin : g_bad_row
      $error("ROW_W must be at least 11: A10 carries the all-bank and auto-precharge flag");
   end
   if (COL_W > AP_BIT) begin : g_bad_col
      $error("COL_W must leave A10 free");
   end
   if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_cl
      $error("CAS_LAT must be 2 or 3");
   end
   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("DATA_W must be a whole number of bytes");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nb
      $error("NBANK must be a power of two, at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RC < 1 || T_MRD < 1 || T_REFI < T_RC + T_RAS + T_RP) begin : g_bad_t
      $error("timing parameters out of range");
   end

   seq_state_e        state, state_d;
   logic [GAP_W-1:0]  gap, gap_d;
   sdr_cmd_e          cmd_d, cmd_q;
   logic [ROW_W-1:0]  addr_d, addr_q;
   logic [BA_W-1:0]   ba_d, ba_q;
   logic [MASK_W-1:0] dqm_d, dqm_q;
   logic [DATA_W-1:0] wd_d, wd_q;
   logic              oe_d, oe_q;
   logic [NBANK-1:0]  act_vec, pre_vec, rd_vec, wr_vec;
   logic [NBANK-1:0]  open_vec, rdwr_ok_vec, pre_ok_vec, act_ok_vec;
   logic [ROW_W-1:0]  open_row [NBANK];
   logic              ref_issue, ref_due;
   logic [CAS_LAT:0]  rd_pipe;

   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      sdr_bank_track #(
         .ROW_W(ROW_W), .AGE_W(AGE_W), .T_RCD(T_RCD), .T_RP(T_RP),
         .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
      ) u_trk (
         .clk(clk), .rst_n(rst_n),
         .do_act(act_vec[i]), .do_pre(pre_vec[i]), .do_rd(rd_vec[i]), .do_wr(wr_vec[i]),
         .row_in(req_row),
         .is_open(open_vec[i]), .open_row(open_row[i]),
         .rdwr_ok(rdwr_ok_vec[i]), .pre_ok(pre_ok_vec[i]), .act_ok(act_ok_vec[i])
      );
   end

   sdr_ref_timer #(.T_REFI(T_REFI)) u_ref (
      .clk(clk), .rst_n(rst_n), .enable(state == ST_RUN),
      .ref_done(ref_issue), .ref_due(ref_due)
   );

   always_comb begin
      state_d   = state;
      gap_d     = (gap != '0) ? gap - GAP_W'(1) : '0;
      cmd_d     = CMD_NOP;
      addr_d    = '0;
      ba_d      = '0;
      dqm_d     = '0;
      wd_d      = '0;
      oe_d      = 1'b0;
      req_ready = 1'b0;
      ref_issue = 1'b0;
      act_vec   = '0;
      pre_vec   = '0;
      rd_vec    = '0;
      wr_vec    = '0;
      if (gap == '0) begin
         unique case (state)
            ST_POWERUP: begin
               cmd_d          = CMD_PRE;
               addr_d[AP_BIT] = 1'b1;
               pre_vec        = '1;
               gap_d          = GAP_W'(T_RP - 1);
               state_d        = ST_INIT_REF1;
            end
            ST_INIT_REF1, ST_INIT_REF2: begin
               cmd_d   = CMD_REF;
               gap_d   = GAP_W'(T_RC - 1);
               state_d = (state == ST_INIT_REF1) ? ST_INIT_REF2 : ST_INIT_LMR;
            end
            ST_INIT_LMR: begin
               cmd_d   = CMD_LMR;
               addr_d  = MODE_WORD;
               gap_d   = GAP_W'(T_MRD - 1);
               state_d = ST_RUN;
            end
            ST_RUN: begin
               if (ref_due) begin
                  if (|open_vec) begin
                     if (&(pre_ok_vec | ~open_vec)) begin
                        cmd_d          = CMD_PRE;
                        addr_d[AP_BIT] = 1'b1;
                        pre_vec        = '1;
                     end
                  end else if (&act_ok_vec) begin
                     cmd_d     = CMD_REF;
                     ref_issue = 1'b1;
                     gap_d     = GAP_W'(T_RC - 1);
                  end
               end else if (req_valid) begin
                  ba_d = req_bank;
                  if (open_vec[req_bank] && open_row[req_bank] == req_row) begin
                     if (rdwr_ok_vec[req_bank]) begin
                        req_ready           = 1'b1;
                        addr_d[COL_W-1:0]   = req_col;
                        if (req_write) begin
                           cmd_d            = CMD_WR;
                           wd_d             = req_wdata;
                           dqm_d            = req_wmask;
                           oe_d             = 1'b1;
                           wr_vec[req_bank] = 1'b1;
                        end else begin
                           cmd_d            = CMD_RD;
                           rd_vec[req_bank] = 1'b1;
                        end
                     end
                  end else if (open_vec[req_bank]) begin
                     if (pre_ok_vec[req_bank]) begin
                        cmd_d             = CMD_PRE;
                        pre_vec[req_bank] = 1'b1;
                     end
                  end else if (act_ok_vec[req_bank]) begin
                     cmd_d             = CMD_ACT;
                     addr_d            = req_row;
                     act_vec[req_bank] = 1'b1;
                  end
               end
            end
            default: state_d = ST_POWERUP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_POWERUP;
         gap      <= GAP_W'(T_INIT);
         cmd_q    <= CMD_NOP;
         addr_q   <= '0;
         ba_q     <= '0;
         dqm_q    <= '0;
         wd_q     <= '0;
         oe_q     <= 1'b0;
         rd_pipe  <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         state    <= state_d;
         gap      <= gap_d;
         cmd_q    <= cmd_d;
         addr_q   <= addr_d;
         ba_q     <= ba_d;
         dqm_q    <= dqm_d;
         wd_q     <= wd_d;
         oe_q     <= oe_d;
         rd_pipe  <= {rd_pipe[CAS_LAT-1:0], (cmd_d == CMD_RD)};
         rd_valid <= rd_pipe[CAS_LAT];
         if (rd_pipe[CAS_LAT]) rd_data <= sd_dq_in;
      end
   end

   assign sd_cke = 1'b1;
   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba     = ba_q;
   assign sd_addr   = addr_q;
   assign sd_dqm    = dqm_q;
   assign sd_dq_out = wd_q;
   assign sd_dq_oe  = oe_q;

   assert_lmr_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LMR) |-> (sd_addr[6:4] == 3'(CAS_LAT) && sd_addr[3:0] == 4'd0));
   assert_no_autopre_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> !sd_addr[AP_BIT]);
   assert_ref_banks_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_issue |-> !(|open_vec));
   assert_ref_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && ref_due) |-> !req_ready);
endmodule

// File: tb/sim_sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_seq_ctrl;
   localparam int CL = 3, TI = 40, TREFI = 150;
   localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 10, T_MRD = 2, T_WR = 2;
   localparam int REF_SLACK = 25;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [0:0]  req_bank = '0;
   logic [10:0] req_row = '0;
   logic [7:0]  req_col = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_wmask = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [0:0]  sd_ba;
   logic [10:0] sd_addr;
   logic [3:0]  sd_dqm;
   logic [31:0] sd_dq_out, sd_dq_in = '0;

   sdram_seq_ctrl #(.CAS_LAT(CL), .T_INIT(TI), .T_REFI(TREFI)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .req_wmask(req_wmask), .rd_valid(rd_valid), .rd_data(rd_data),
      .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] m);
      for (int i = 0; i < 4; i++) if (!m[i]) o[8*i +: 8] = n[8*i +: 8];
      return o;
   endfunction

   function automatic int key(int b, int row, int col);
      return b * 524288 + row * 256 + col;
   endfunction

   // Cycle-level memory model: decodes pins and measures spacing.
   int cyc = 0, rst_cyc = 0;
   int last_act[2] = '{-1000, -1000}, last_pre[2] = '{-1000, -1000}, last_wr[2] = '{-1000, -1000};
   int last_ref = -1000, last_lmr = -1000;
   bit bopen[2] = '{0, 0};
   int orow[2];
   int n_act = 0, n_ref = 0, init_step = 0, early_ready = 0;
   bit init_ok = 0, ref_late = 0;
   logic [31:0] mem [int];
   int rq_due[$];
   logic [31:0] rq_dat[$];

   always @(negedge clk) begin
      logic [3:0] c;
      int b;
      cyc++;
      if (!rst_n) rst_cyc = cyc;
      if (rq_due.size() != 0 && rq_due[0] == cyc) begin
         sd_dq_in = rq_dat.pop_front();
         void'(rq_due.pop_front());
      end
      if (rst_n) begin
         c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         b = int'(sd_ba);
         if (req_ready && !init_ok) early_ready++;
         if (init_ok && !ref_late && cyc - last_ref > TREFI + REF_SLACK) begin
            ref_late = 1;
            chk(0, "R10", "refresh gap", cyc - last_ref, TREFI + REF_SLACK);
         end
         if (c != 4'b0111) begin
            chk(c inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0001, 4'b0000}, "R1", "command code", c, 0);
            chk(sd_cke, "R11", "cke", sd_cke, 1);
            if (!init_ok) begin
               case (init_step)
                  0: begin
                     chk(c == 4'b0010 && sd_addr[10], "R2", "first init cmd", c, 4'b0010);
                     chk(cyc - rst_cyc >= TI, "R2", "power-up wait", cyc - rst_cyc, TI);
                  end
                  1, 2: chk(c == 4'b0001, "R2", "init refresh", c, 4'b0001);
                  default: chk(c == 4'b0000, "R2", "init mode load", c, 4'b0000);
               endcase
               init_step++;
            end
            case (c)
               4'b0011: begin
                  chk(!bopen[b], "R6", "activate on open bank", bopen[b], 0);
                  chk(cyc - last_pre[b] >= T_RP, "R7", "PRE->ACT", cyc - last_pre[b], T_RP);
                  chk(cyc - last_act[b] >= T_RC, "R7", "ACT->ACT", cyc - last_act[b], T_RC);
                  chk(cyc - last_ref >= T_RC, "R7", "REF->ACT", cyc - last_ref, T_RC);
                  chk(cyc - last_lmr >= T_MRD, "R7", "LMR->ACT", cyc - last_lmr, T_MRD);
                  bopen[b] = 1; orow[b] = int'(sd_addr); last_act[b] = cyc; n_act++;
               end
               4'b0101, 4'b0100: begin
                  int k;
                  chk(bopen[b], "R4", "column cmd to closed bank", bopen[b], 1);
                  chk(!sd_addr[10], "R4", "auto-precharge bit", sd_addr[10], 0);
                  chk(cyc - last_act[b] >= T_RCD, "R7", "ACT->RD/WR", cyc - last_act[b], T_RCD);
                  k = key(b, orow[b], int'(sd_addr[7:0]));
                  if (c == 4'b0100) begin
                     chk(sd_dq_oe, "R8", "bus drive on write", sd_dq_oe, 1);
                     mem[k] = merge(mem.exists(k) ? mem[k] : 32'h0, sd_dq_out, sd_dqm);
                     last_wr[b] = cyc;
                  end else begin
                     rq_due.push_back(cyc + CL);
                     rq_dat.push_back(mem.exists(k) ? mem[k] : 32'h0);
                  end
               end
               4'b0010: begin
                  for (int i = 0; i < 2; i++) begin
                     if (sd_addr[10] || i == b) begin
                        if (bopen[i]) begin
                           chk(cyc - last_act[i] >= T_RAS, "R7", "ACT->PRE", cyc - last_act[i], T_RAS);
                           chk(cyc - last_wr[i] >= T_WR, "R7", "WR->PRE", cyc - last_wr[i], T_WR);
                        end
                        bopen[i] = 0; last_pre[i] = cyc;
                     end
                  end
               end
               4'b0001: begin
                  chk(!bopen[0] && !bopen[1], "R10", "refresh with open row", {bopen[1], bopen[0]}, 0);
                  chk(cyc - last_ref >= T_RC, "R7", "REF->REF", cyc - last_ref, T_RC);
                  for (int i = 0; i < 2; i++) begin
                     chk(cyc - last_pre[i] >= T_RP, "R7", "PRE->REF", cyc - last_pre[i], T_RP);
                     chk(cyc - last_act[i] >= T_RC, "R7", "ACT->REF", cyc - last_act[i], T_RC);
                  end
                  last_ref = cyc; n_ref++;
               end
               4'b0000: begin
                  chk(sd_addr == 11'(CL << 4), "R3", "mode opcode", sd_addr, 11'(CL << 4));
                  chk(sd_ba == 1'b0, "R3", "mode bank bits", sd_ba, 0);
                  last_lmr = cyc;
                  if (init_step >= 4) init_ok = 1;
               end
               default: ;
            endcase
         end
      end
   end

   // Scoreboard: the driver pushes expected reads, the monitor pops them.
   logic [31:0] mirror [int];
   logic [31:0] exp_q[$];

   task automatic xfer(bit wr, int b, int row, int col, logic [31:0] d, logic [3:0] m);
      int k;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_bank = 1'(b); req_row = 11'(row);
      req_col = 8'(col); req_wdata = d; req_wmask = m;
      forever begin
         #1;
         if (req_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
      req_valid = 0;
      k = key(b, row, col);
      if (wr) mirror[k] = merge(mirror.exists(k) ? mirror[k] : 32'h0, d, m);
      else exp_q.push_back(mirror.exists(k) ? mirror[k] : 32'h0);
   endtask

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(0, "R9", "unexpected read result", rd_data, 0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R9", "read data", rd_data, e);
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog", "run did not finish", 0, 1);
         finish_run();
      end
   end

   initial begin
      int a0, r0;
      repeat (5) @(negedge clk);
      chk(sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2", "reset state", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      rst_n = 1;
      // R2: request presented at once; must wait for init.
      xfer(1, 0, 5, 1, 32'hA1B2C3D4, 4'b0000);
      chk(early_ready == 0, "R2", "accepted before init done", early_ready, 0);
      // R5: row hit.
      a0 = n_act; r0 = n_ref;
      xfer(0, 0, 5, 1, 0, 0);
      repeat (2) @(negedge clk);
      chk(n_act == a0 || n_ref != r0, "R5", "activates on row hit", n_act - a0, 0);
      // R8: masked write then read.
      xfer(1, 0, 5, 1, 32'h11223344, 4'b0101);
      xfer(0, 0, 5, 1, 0, 0);
      // R6: bank 1 open, miss on bank 0, bank 1 still open.
      xfer(1, 1, 7, 200, 32'hDEADBEEF, 4'b0000);
      xfer(1, 0, 9, 3, 32'h0BADF00D, 4'b1000);
      a0 = n_act; r0 = n_ref;
      xfer(0, 1, 7, 200, 0, 0);
      repeat (2) @(negedge clk);
      chk(n_act == a0 || n_ref != r0, "R6", "other bank kept open", n_act - a0, 0);
      xfer(0, 0, 5, 1, 0, 0);
      xfer(0, 0, 9, 3, 0, 0);
      // Mixed stream across banks, rows and columns, running through refreshes.
      for (int i = 0; i < 40; i++)
         xfer(1, i % 2, (i * 37) % 2048, (i * 13) % 256, 32'h1000_0000 + i * 32'h01010101, 4'(i % 16));
      for (int i = 0; i < 40; i++)
         xfer(0, i % 2, (i * 37) % 2048, (i * 13) % 256, 0, 0);
      // R10: idle period still refreshes.
      r0 = n_ref;
      repeat (4 * TREFI) @(negedge clk);
      chk(n_ref - r0 >= 3, "R10", "refreshes while idle", n_ref - r0, 3);
      chk(!ref_late, "R10", "refresh interval bound", ref_late, 0);
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R9", "outstanding reads", exp_q.size(), 0);
      done = 1;
      finish_run();
   end
endmodule